// File: doc/BRIEF.md
# Physical link connection sequencer

This block steps a point-to-point fibre ring link from power-up through to an active connection. A host supplies a 2-bit command and two request bits: maintenance and join. The receive side supplies the recognised line state. Two external down-counting timers deliver single-cycle expiry pulses: a connection timer and a noise timer. From these inputs the sequencer keeps one of ten numbered states. Each time it falls back to BREAK, it records the reason in an encoded cause register.

Two dwell times are set by parameters and counted inside the block: the minimum break time and the minimum connect time. The bit-signalling exchange is reduced to a placeholder phase. That phase ends when the connection timer expires. The outputs are the state code, the last break cause, a one-cycle break-entry pulse and a one-cycle trace-propagation pulse. All outputs are registered.

Top module: `link_conn_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `state` is 0 (OFF), `break_reason` is 0, and `break_pulse` and `trace_prop` are 0.
- R2: A non-zero `cmd` takes effect at the next clock edge from any state and overrides every other input. 1 enters BREAK with cause 1 (re-entering BREAK if already there). 2 enters TRACE. 3 enters OFF. 0 has no effect.
- R3: The `state` codes are OFF=0, BREAK=1, TRACE=2, CONNECT=3, NEXT=4, SIGNAL=5, JOIN=6, VERIFY=7, ACTIVE=8, MAINT=9. With `cmd`=0, only R4 to R10 change the state.
- R4: In OFF, `maint_req` moves the machine to MAINT. MAINT is left only by a command. `maint_req` has no effect in any other state.
- R5: BREAK is shown for exactly TB_MIN consecutive cycles after entry, then CONNECT follows. A start command during BREAK restarts the count.
- R6: CONNECT is shown for exactly C_MIN cycles, then NEXT follows, unless a break condition intervenes.
- R7: In NEXT, `join_req` leads to JOIN, otherwise SIGNAL follows. In SIGNAL, a `tpc_exp` pulse returns to NEXT and nothing else advances it.
- R8: JOIN leads to VERIFY, and VERIFY leads to ACTIVE, one cycle each. ACTIVE holds.
- R9: `tpc_exp` in CONNECT, NEXT, JOIN, VERIFY or TRACE enters BREAK with cause 2. `tne_exp` in any state from TRACE through ACTIVE (codes 2 to 8) enters BREAK with cause 3.
- R10: The `line_st` codes are 0 noise, 1 active, 2 quiet, 3 idle, 4 master, 5 halt. In NEXT, SIGNAL, JOIN, VERIFY and ACTIVE, quiet enters BREAK with cause 4 and halt with cause 6. In TRACE, idle enters BREAK with cause 5. When causes coincide, priority is 2 > 3 > 4 > 5 > 6.
- R11: `break_pulse` is 1 for exactly the first cycle in which `state` shows a fresh entry into BREAK, re-entries included.
- R12: `break_reason` changes only on a BREAK entry and otherwise keeps the last cause.
- R13: `trace_prop` is 1 in the cycle after a master line state (4) is received while the state is ACTIVE or TRACE, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Host command: 0 none, 1 start, 2 trace, 3 stop |
| maint_req | input | 1 | Maintenance request, honoured in OFF |
| join_req | input | 1 | Join request, honoured in NEXT |
| line_st | input | 3 | Recognised receive line state |
| tpc_exp | input | 1 | Connection timer expiry pulse |
| tne_exp | input | 1 | Noise timer expiry pulse |
| state | output | 4 | Current sequencer state code |
| break_reason | output | 3 | Cause of the most recent BREAK entry |
| break_pulse | output | 1 | One-cycle pulse on BREAK entry |
| trace_prop | output | 1 | One-cycle trace-propagation event |

## Verification
A host command and a timer expiry or bad line state can arrive in the same cycle. Both would force BREAK, but with different causes, or with BREAK competing against TRACE or OFF. Directed cases drive a start command together with a connection-timer pulse in CONNECT, and a timer pulse together with a quiet line in NEXT. The recorded cause must be 1 in the first case and 2 in the second. Random stimulus also makes such collisions often, and a bench model of the requirements judges each cycle's state, cause and pulses.

// File: rtl/link_conn_seq.sv
module link_conn_seq #(
  parameter int TB_MIN = 4,
  parameter int C_MIN  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd,
  input  logic       maint_req,
  input  logic       join_req,
  input  logic [2:0] line_st,
  input  logic       tpc_exp,
  input  logic       tne_exp,
  output logic [3:0] state,
  output logic [2:0] break_reason,
  output logic       break_pulse,
  output logic       trace_prop
);
  localparam int DMAX = (TB_MIN > C_MIN) ? TB_MIN : C_MIN;
  localparam int CW   = $clog2(DMAX + 1);

  localparam logic [3:0] S_OFF = 4'd0, S_BRK = 4'd1, S_TRC = 4'd2, S_CON = 4'd3,
                         S_NXT = 4'd4, S_SIG = 4'd5, S_JON = 4'd6, S_VER = 4'd7,
                         S_ACT = 4'd8, S_MNT = 4'd9;
  localparam logic [2:0] L_QUIET = 3'd2, L_IDLE = 3'd3, L_MASTER = 3'd4, L_HALT = 3'd5;

  logic [3:0]    nxt;
  logic [2:0]    cause, auto_cause;
  logic [CW-1:0] cnt;

  wire tpc_set = state inside {S_CON, S_NXT, S_JON, S_VER, S_TRC};
  wire tne_set = state inside {S_TRC, S_CON, S_NXT, S_SIG, S_JON, S_VER, S_ACT};
  wire ls_set  = state inside {S_NXT, S_SIG, S_JON, S_VER, S_ACT};

  always_comb begin
    if (tpc_exp && tpc_set)                      auto_cause = 3'd2;
    else if (tne_exp && tne_set)                 auto_cause = 3'd3;
    else if (line_st == L_QUIET && ls_set)       auto_cause = 3'd4;
    else if (line_st == L_IDLE && state == S_TRC) auto_cause = 3'd5;
    else if (line_st == L_HALT && ls_set)        auto_cause = 3'd6;
    else                                         auto_cause = 3'd0;
  end

  always_comb begin
    nxt   = state;
    cause = 3'd0;
    if (cmd == 2'd1) begin
      nxt = S_BRK; cause = 3'd1;
    end else if (cmd == 2'd2) begin
      nxt = S_TRC;
    end else if (cmd == 2'd3) begin
      nxt = S_OFF;
    end else if (auto_cause != 3'd0) begin
      nxt = S_BRK; cause = auto_cause;
    end else begin
      case (state)
        S_OFF: if (maint_req) nxt = S_MNT;
        S_BRK: if (cnt == CW'(TB_MIN - 1)) nxt = S_CON;
        S_CON: if (cnt == CW'(C_MIN - 1)) nxt = S_NXT;
        S_NXT: nxt = join_req ? S_JON : S_SIG;
        S_SIG: if (tpc_exp) nxt = S_NXT;
        S_JON: nxt = S_VER;
        S_VER: nxt = S_ACT;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_OFF;
      break_reason <= 3'd0;
      break_pulse  <= 1'b0;
      trace_prop   <= 1'b0;
      cnt          <= '0;
    end else begin
      state       <= nxt;
      break_pulse <= (cause != 3'd0);
      if (cause != 3'd0) break_reason <= cause;
      trace_prop  <= (line_st == L_MASTER) && (state == S_ACT || state == S_TRC);
      if (nxt != state || cause != 3'd0)      cnt <= '0;
      else if (state == S_BRK || state == S_CON) cnt <= cnt + 1'b1;
    end
  end

  assert_stop_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 2'd3 |=> state == S_OFF);
  assert_maint_from_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OFF && cmd == 2'd0 && maint_req) |=> state == S_MNT);
  assert_join_to_verify_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_JON && cmd == 2'd0 && !tpc_exp && !tne_exp &&
     line_st != L_QUIET && line_st != L_HALT) |=> state == S_VER);
  assert_pulse_in_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
    break_pulse |-> state == S_BRK);
  assert_reason_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !break_pulse |-> $stable(break_reason));
  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state <= S_MNT);
  assert_trace_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
    trace_prop |-> ($past(state) == S_ACT || $past(state) == S_TRC));
endmodule

// File: tb/link_conn_seq_test.sv
module link_conn_seq_test;
  localparam int PER = 10;
  localparam int TB = 4;
  localparam int CM = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] cmd = 0;
  logic maint_req = 0, join_req = 0, tpc_exp = 0, tne_exp = 0;
  logic [2:0] line_st = 0;
  logic [3:0] state;
  logic [2:0] break_reason;
  logic break_pulse, trace_prop;

  int n_run = 0, n_fail = 0;
  int m_state = 0, m_reason = 0, m_pulse = 0, m_trace = 0, m_cnt = 0;

  link_conn_seq #(.TB_MIN(TB), .C_MIN(CM)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .maint_req(maint_req), .join_req(join_req),
    .line_st(line_st), .tpc_exp(tpc_exp), .tne_exp(tne_exp), .state(state),
    .break_reason(break_reason), .break_pulse(break_pulse), .trace_prop(trace_prop));

  always #(PER/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int auto_cause(int s);
    bit tset = s inside {3, 4, 6, 7, 2};
    bit nset = s inside {2, 3, 4, 5, 6, 7, 8};
    bit lset = s inside {4, 5, 6, 7, 8};
    if (tpc_exp && tset) return 2;
    if (tne_exp && nset) return 3;
    if (line_st == 2 && lset) return 4;
    if (line_st == 3 && s == 2) return 5;
    if (line_st == 5 && lset) return 6;
    return 0;
  endfunction

  task automatic model_step();
    int nx = m_state, c = 0, ac;
    ac = auto_cause(m_state);
    if (cmd == 1) begin nx = 1; c = 1; end
    else if (cmd == 2) nx = 2;
    else if (cmd == 3) nx = 0;
    else if (ac != 0) begin nx = 1; c = ac; end
    else case (m_state)
      0: if (maint_req) nx = 9;
      1: if (m_cnt == TB - 1) nx = 3;
      3: if (m_cnt == CM - 1) nx = 4;
      4: nx = join_req ? 6 : 5;
      5: if (tpc_exp) nx = 4;
      6: nx = 7;
      7: nx = 8;
      default: ;
    endcase
    m_trace = (line_st == 4 && (m_state == 8 || m_state == 2)) ? 1 : 0;
    m_pulse = (c != 0) ? 1 : 0;
    if (c != 0) m_reason = c;
    if (nx != m_state || c != 0) m_cnt = 0; else m_cnt++;
    m_state = nx;
  endtask

  task automatic cyc(input int c, input bit mr, input bit jr, input int ls, input bit tp, input bit tn);
    @(negedge clk);
    cmd = 2'(c); maint_req = mr; join_req = jr; line_st = 3'(ls); tpc_exp = tp; tne_exp = tn;
    @(posedge clk); #1;
    model_step();
    chk("R3 state", state, m_state);
    chk("R12 reason", break_reason, m_reason);
    chk("R11 pulse", break_pulse, m_pulse);
    chk("R13 trace", trace_prop, m_trace);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    #(PER * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #(PER * 3 + 2);
    chk("R1 reset state", state, 0);
    chk("R1 reset reason", break_reason, 0);
    chk("R1 reset pulses", {break_pulse, trace_prop}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 first cycle state", state, 0);

    cyc(0, 0, 1, 2, 1, 1);
    chk("R4 OFF ignores other inputs", state, 0);
    cyc(0, 1, 0, 1, 0, 0);
    chk("R4 maint from OFF", state, 9);
    cyc(0, 0, 1, 2, 1, 1);
    chk("R4 MAINT held", state, 9);
    cyc(1, 0, 0, 1, 0, 0);
    chk("R2 start enters BREAK", state, 1);
    chk("R11 pulse on entry", break_pulse, 1);
    chk("R2 cause start", break_reason, 1);
    idle(TB - 2);
    cyc(0, 1, 0, 1, 0, 0);
    chk("R4 maint ignored in BREAK", state, 1);
    cyc(1, 0, 0, 1, 0, 0);
    chk("R5 re-entry pulses", break_pulse, 1);
    idle(TB - 1);
    chk("R5 still BREAK", state, 1);
    idle(1);
    chk("R5 BREAK to CONNECT", state, 3);
    idle(CM - 1);
    chk("R6 still CONNECT", state, 3);
    idle(1);
    chk("R6 CONNECT to NEXT", state, 4);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7 NEXT to SIGNAL", state, 5);
    idle(3);
    chk("R7 SIGNAL waits", state, 5);
    cyc(0, 0, 0, 1, 1, 0);
    chk("R7 SIGNAL ends on timer", state, 4);
    cyc(0, 0, 1, 1, 0, 0);
    chk("R7 join", state, 6);
    idle(1);
    chk("R8 VERIFY", state, 7);
    idle(1);
    chk("R8 ACTIVE", state, 8);
    cyc(0, 0, 0, 1, 1, 0);
    chk("R9 ACTIVE ignores conn timer", state, 8);
    cyc(0, 0, 0, 4, 0, 0);
    chk("R13 trace event", trace_prop, 1);
    cyc(0, 0, 0, 2, 0, 0);
    chk("R10 quiet cause", break_reason, 4);
    idle(TB);
    chk("R5 reach CONNECT", state, 3);
    cyc(1, 0, 0, 1, 1, 0);
    chk("R2 cmd beats timer cause", break_reason, 1);
    idle(TB + CM);
    chk("R6 reach NEXT", state, 4);
    cyc(0, 0, 0, 2, 1, 0);
    chk("R10 timer beats quiet", break_reason, 2);
    cyc(2, 0, 0, 1, 0, 0);
    chk("R2 trace command", state, 2);
    cyc(0, 0, 0, 3, 0, 1);
    chk("R9 noise cause beats idle", break_reason, 3);
    cyc(2, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 3, 0, 0);
    chk("R10 idle in TRACE", break_reason, 5);
    cyc(3, 0, 0, 1, 0, 0);
    chk("R2 stop", state, 0);

    for (int i = 0; i < 4000; i++) begin
      int c, ls;
      c  = ($urandom % 20 == 0) ? int'($urandom % 4) : 0;
      ls = ($urandom % 4 == 0) ? int'($urandom % 6) : 1;
      cyc(c, ($urandom % 8) == 0, ($urandom % 2) == 0, ls,
          ($urandom % 12) == 0, ($urandom % 16) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule